// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block drives the command and address pins of a single-rank DDR SDRAM built from four banks. It leaves rows open after use. A client presents one request at a time: a bank, a row, a column, a read/write flag and an auto-precharge flag. The block keeps the open row and the timing state of every bank. It then issues the shortest legal series of commands for the request. A row hit goes straight to READ or WRITE. A row miss first closes the bank, then activates the new row, and then performs the access. A closed bank is activated before the access.

After reset the block holds the clock-enable pin low for a programmable number of cycles. It then closes all banks and loads the extended and base mode registers. From then on it runs a periodic refresh timer. When the timer expires, the refresh is handled before any further request. All open banks are closed with a precharge-all command. The block waits until every bank has recovered, issues AUTO REFRESH, and keeps the bus idle for the refresh recovery time. All timing is counted in clock cycles, using parameters for activate-to-access, precharge, row cycle, refresh cycle, mode-register and refresh-interval.

Top module: `ddr_cmd_seq`

## Requirements
- R1: After reset, clock enable stays low and the bus carries NOP for at least INIT_CYC cycles. The first three commands are, in order: PRECHARGE with A10 high; LOAD MODE REGISTER with BA=01 and A=0, no sooner than T_RP cycles later; and LOAD MODE REGISTER with BA=00.
- R2: The command code on {cs_n, ras_n, cas_n, we_n} is one of the following: NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, REFRESH=0001, LOAD MODE=0000. A write request produces WRITE and a read request produces READ.
- R3: On READ/WRITE, BA carries the requested bank and A10 carries the auto-precharge flag. Column bit 10 goes out on A11, column bits 9..0 go out on A9..A0, and A12 is 0.
- R4: At least T_RCD cycles separate an ACTIVE from a READ or WRITE to the same bank.
- R5: At least T_RP cycles separate a PRECHARGE covering a bank from the next ACTIVE to that bank. After an access with auto-precharge, the next ACTIVE to that bank comes at least BURST_LEN/2+T_RP cycles later.
- R6: At least T_RC cycles separate two ACTIVE commands to the same bank.
- R7: A request to an open bank holding a different row produces exactly one PRECHARGE with A10 low to that bank, then one ACTIVE carrying the new row on A, then the access. ACTIVE is never issued to an open bank, and an access never goes to a closed bank.
- R8: A request that hits the open row of its bank is served with no ACTIVE and no PRECHARGE.
- R9: AUTO REFRESH is issued only when every bank is closed, with each bank past its precharge and row-cycle times. For T_RFC cycles after it, only NOP appears. Refreshes keep coming while the block runs, busy or idle.
- R10: Once a refresh is due, no ACTIVE, READ or WRITE is issued until the refresh has been issued. Consecutive refreshes are therefore at most T_REFI plus a small fixed slack apart, even under continuous request traffic.
- R11: The base mode word has A2..A0 as the burst-length code (2→001, 4→010, 8→011), A3 as 0 (sequential), A6..A4 as the CAS-latency code (2→010, 3→011), and all upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the bank after this access |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_ready | output | 1 | The request is consumed at this clock edge |
| init_done | output | 1 | Power-up sequence finished |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ROW_W | Row/column/opcode address |

## Verification
The assertions watch the bus on every cycle. They measure the spacing of ACTIVE, READ/WRITE and PRECHARGE on each bank with their own counters. They also check that only NOP appears while clock enable is low or while a refresh is recovering, and that no access or activate slips out while a refresh is pending. The bench covers what a single-cycle property cannot show: that a row hit needs no extra commands while a miss needs exactly one close and one open, the order and contents of the power-up commands, the column-to-pin mapping of each access, and the bounded interval between refreshes under random back-to-back traffic and during long idle stretches.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_LMR = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_ACT = 4'b0011,
      CMD_WR  = 4'b0100,
      CMD_RD  = 4'b0101,
      CMD_NOP = 4'b0111
   } ddr_cmd_e;

   typedef enum logic [2:0] {
      ST_PWRUP,
      ST_INIT_PRE,
      ST_INIT_EMR,
      ST_INIT_MR,
      ST_RUN
   } seq_state_e;

   function automatic logic [2:0] bl_code(input int bl);
      case (bl)
         2:       return 3'b001;
         4:       return 3'b010;
         default: return 3'b011;
      endcase
   endfunction

   function automatic logic [2:0] cl_code(input int cl);
      return (cl == 2) ? 3'b010 : 3'b011;
   endfunction

endpackage

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
   parameter int ROW_W = 13,
   parameter int T_RCD = 3,
   parameter int T_RC  = 11,
   parameter int T_RP  = 3,
   parameter int T_AP  = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic             pre_i,
   input  logic             acc_i,
   input  logic             ap_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             act_ok_o,
   output logic             acc_ok_o
);
   localparam int MAXT  = (T_RC > T_AP) ? ((T_RC > T_RP) ? T_RC : T_RP)
                                         : ((T_AP > T_RP) ? T_AP : T_RP);
   localparam int CNT_W = $clog2(MAXT + 1);

   logic [CNT_W-1:0] rcd_left, rc_left, rp_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_o   <= 1'b0;
         row_o    <= '0;
         rcd_left <= '0;
         rc_left  <= '0;
         rp_left  <= '0;
      end else begin
         if (rcd_left != '0) rcd_left <= rcd_left - 1'b1;
         if (rc_left  != '0) rc_left  <= rc_left  - 1'b1;
         if (rp_left  != '0) rp_left  <= rp_left  - 1'b1;
         if (act_i) begin
            open_o   <= 1'b1;
            row_o    <= row_i;
            rcd_left <= CNT_W'(T_RCD - 1);
            rc_left  <= CNT_W'(T_RC - 1);
         end else if (pre_i) begin
            open_o  <= 1'b0;
            rp_left <= CNT_W'(T_RP - 1);
         end else if (acc_i && ap_i) begin
            open_o  <= 1'b0;
            rp_left <= CNT_W'(T_AP - 1);
         end
      end
   end

   assign act_ok_o = !open_o && (rc_left == '0) && (rp_left == '0);
   assign acc_ok_o = open_o && (rcd_left == '0);

   AST_ONE_BANK_OP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({act_i, pre_i, acc_i}) <= 1); // R7
   AST_ACT_ROW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |=> (open_o && row_o == $past(row_i))); // R7

endmodule

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer #(
   parameter int T_REFI = 1562
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic ref_done_i,
   output logic due_o
);
   localparam int CW = $clog2(T_REFI);

   logic [CW-1:0] left;
   logic          expire;

   assign expire = run_i && (left == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left  <= CW'(T_REFI - 1);
         due_o <= 1'b0;
      end else begin
         if (run_i) left <= expire ? CW'(T_REFI - 1) : left - 1'b1;
         due_o <= expire | (due_o & ~ref_done_i);
      end
   end

   AST_DUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (due_o && !ref_done_i) |=> due_o); // R10
   AST_DONE_NEEDS_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      ref_done_i |-> due_o); // R9

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
   import ddr_seq_pkg::*;
#(
   parameter int BA_W      = 2,
   parameter int ROW_W     = 13,
   parameter int COL_W     = 11,
   parameter int BURST_LEN = 4,
   parameter int CAS_LAT   = 3,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RC      = 11,
   parameter int T_RFC     = 14,
   parameter int T_MRD     = 2,
   parameter int T_REFI    = 1562,
   parameter int INIT_CYC  = 20
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             req_ap,
   input  logic [BA_W-1:0]  req_bank,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   output logic             req_ready,
   output logic             init_done,
   output logic             ddr_cke,
   output logic             ddr_cs_n,
   output logic             ddr_ras_n,
   output logic             ddr_cas_n,
   output logic             ddr_we_n,
   output logic [BA_W-1:0]  ddr_ba,
   output logic [ROW_W-1:0] ddr_addr
);
   localparam int NUM_BANK = 1 << BA_W;
   localparam int T_AP     = BURST_LEN / 2 + T_RP;
   localparam int GW_A     = (INIT_CYC > T_RFC) ? INIT_CYC : T_RFC;
   localparam int GW_B     = (T_RP > T_MRD) ? T_RP : T_MRD;
   localparam int GW_MAX   = (GW_A > GW_B) ? GW_A : GW_B;
   localparam int GW_W     = $clog2(GW_MAX + 1);
   localparam int SW_MAX   = T_RC + T_RFC + T_AP;
   localparam int SW_W     = $clog2(SW_MAX + 1);
   localparam logic [ROW_W-1:0] MODE_WORD =
      ROW_W'({cl_code(CAS_LAT), 1'b0, bl_code(BURST_LEN)});

   // elaboration-time parameter checks
   if (!(BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_bl
      $error("burst length must be 2, 4 or 8");
   end
   if (!(CAS_LAT == 2 || CAS_LAT == 3)) begin : g_bad_cl
      $error("CAS latency must be 2 or 3");
   end
   if (ROW_W < 11 || COL_W > ROW_W - 1 || COL_W < 1) begin : g_bad_addr
      $error("address widths leave no room for the A10 flag");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RC < T_RCD || T_MRD < 1 || T_RFC < 1 ||
       INIT_CYC < 1 || T_REFI < 2 * (T_RC + T_RFC + T_AP)) begin : g_bad_tim
      $error("inconsistent timing parameters");
   end

   seq_state_e          state, nxt_state;
   ddr_cmd_e            cmd_q, nxt_cmd;
   logic [BA_W-1:0]     ba_q, nxt_ba;
   logic [ROW_W-1:0]    a_q, nxt_a, acc_addr;
   logic                cke_q, cke_set;
   logic [GW_W-1:0]     gw, gw_val;
   logic                gw_load;
   logic [NUM_BANK-1:0] act_v, pre_v, acc_v;
   logic [NUM_BANK-1:0] bank_open, bank_act_ok, bank_acc_ok;
   logic [ROW_W-1:0]    bank_row [NUM_BANK];
   logic                ref_due, ref_done;
   logic [BA_W-1:0]     rb;
   logic                all_closed, all_ready;
   logic [3:0]          cmd_bits;

   assign rb         = req_bank;
   assign all_closed = ~|bank_open;
   assign all_ready  = &bank_act_ok;

   // column placement around the A10 flag
   if (COL_W > 10) begin : g_wide_col
      always_comb begin
         acc_addr                = '0;
         acc_addr[9:0]           = req_col[9:0];
         acc_addr[COL_W:11]      = req_col[COL_W-1:10];
         acc_addr[10]            = req_ap;
      end
   end else begin : g_narrow_col
      always_comb begin
         acc_addr                = '0;
         acc_addr[COL_W-1:0]     = req_col;
         acc_addr[10]            = req_ap;
      end
   end

   for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
      ddr_bank_track #(
         .ROW_W (ROW_W),
         .T_RCD (T_RCD),
         .T_RC  (T_RC),
         .T_RP  (T_RP),
         .T_AP  (T_AP)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .act_i    (act_v[b]),
         .pre_i    (pre_v[b]),
         .acc_i    (acc_v[b]),
         .ap_i     (req_ap),
         .row_i    (req_row),
         .open_o   (bank_open[b]),
         .row_o    (bank_row[b]),
         .act_ok_o (bank_act_ok[b]),
         .acc_ok_o (bank_acc_ok[b])
      );

      // bus-side spacing watchers, independent of the bank counters
      logic            on_b;
      logic [SW_W-1:0] since_act, since_pre, since_ap;
      assign on_b = (ba_q == BA_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            since_act <= '1;
            since_pre <= '1;
            since_ap  <= '1;
         end else begin
            since_act <= (cmd_q == CMD_ACT && on_b) ? SW_W'(1) :
                         (since_act == '1) ? since_act : since_act + 1'b1;
            since_pre <= (cmd_q == CMD_PRE && (a_q[10] || on_b)) ? SW_W'(1) :
                         (since_pre == '1) ? since_pre : since_pre + 1'b1;
            since_ap  <= ((cmd_q == CMD_RD || cmd_q == CMD_WR) && on_b && a_q[10]) ? SW_W'(1) :
                         (since_ap == '1) ? since_ap : since_ap + 1'b1;
         end
      end

      AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
         ((cmd_q == CMD_RD || cmd_q == CMD_WR) && on_b) |-> since_act >= SW_W'(T_RCD)); // R4
      AST_RP_MET: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_q == CMD_ACT && on_b) |-> (since_pre >= SW_W'(T_RP) && since_ap >= SW_W'(T_AP))); // R5
      AST_RC_MET: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_q == CMD_ACT && on_b) |-> since_act >= SW_W'(T_RC)); // R6
   end

   ddr_refresh_timer #(
      .T_REFI (T_REFI)
   ) u_refresh (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (state == ST_RUN),
      .ref_done_i (ref_done),
      .due_o      (ref_due)
   );

   always_comb begin
      nxt_state = state;
      nxt_cmd   = CMD_NOP;
      nxt_ba    = '0;
      nxt_a     = '0;
      act_v     = '0;
      pre_v     = '0;
      acc_v     = '0;
      req_ready = 1'b0;
      ref_done  = 1'b0;
      cke_set   = 1'b0;
      gw_load   = 1'b0;
      gw_val    = '0;
      if (gw == '0) begin
         case (state)
            ST_PWRUP: begin
               cke_set   = 1'b1;
               nxt_state = ST_INIT_PRE;
            end
            ST_INIT_PRE: begin
               nxt_cmd   = CMD_PRE;
               nxt_a[10] = 1'b1;
               pre_v     = '1;
               gw_load   = 1'b1;
               gw_val    = GW_W'(T_RP - 1);
               nxt_state = ST_INIT_EMR;
            end
            ST_INIT_EMR: begin
               nxt_cmd   = CMD_LMR;
               nxt_ba    = BA_W'(1);
               gw_load   = 1'b1;
               gw_val    = GW_W'(T_MRD - 1);
               nxt_state = ST_INIT_MR;
            end
            ST_INIT_MR: begin
               nxt_cmd   = CMD_LMR;
               nxt_a     = MODE_WORD;
               gw_load   = 1'b1;
               gw_val    = GW_W'(T_MRD - 1);
               nxt_state = ST_RUN;
            end
            ST_RUN: begin
               if (ref_due) begin
                  if (!all_closed) begin
                     nxt_cmd   = CMD_PRE;
                     nxt_a[10] = 1'b1;
                     pre_v     = '1;
                  end else if (all_ready) begin
                     nxt_cmd  = CMD_REF;
                     ref_done = 1'b1;
                     gw_load  = 1'b1;
                     gw_val   = GW_W'(T_RFC - 1);
                  end
               end else if (req_valid) begin
                  if (bank_open[rb] && bank_row[rb] == req_row) begin
                     if (bank_acc_ok[rb]) begin
                        nxt_cmd   = req_write ? CMD_WR : CMD_RD;
                        nxt_ba    = rb;
                        nxt_a     = acc_addr;
                        acc_v[rb] = 1'b1;
                        req_ready = 1'b1;
                     end
                  end else if (bank_open[rb]) begin
                     nxt_cmd   = CMD_PRE;
                     nxt_ba    = rb;
                     pre_v[rb] = 1'b1;
                  end else if (bank_act_ok[rb]) begin
                     nxt_cmd   = CMD_ACT;
                     nxt_ba    = rb;
                     nxt_a     = req_row;
                     act_v[rb] = 1'b1;
                  end
               end
            end
            default: nxt_state = ST_PWRUP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_PWRUP;
         gw    <= GW_W'(INIT_CYC - 1);
         cmd_q <= CMD_NOP;
         ba_q  <= '0;
         a_q   <= '0;
         cke_q <= 1'b0;
      end else begin
         state <= nxt_state;
         cmd_q <= nxt_cmd;
         ba_q  <= nxt_ba;
         a_q   <= nxt_a;
         if (cke_set) cke_q <= 1'b1;
         if (gw_load)         gw <= gw_val;
         else if (gw != '0)   gw <= gw - 1'b1;
      end
   end

   // refresh recovery watcher
   logic [SW_W-1:0] since_ref;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_ref <= '1;
      else        since_ref <= (cmd_q == CMD_REF) ? SW_W'(1) :
                               (since_ref == '1) ? since_ref : since_ref + 1'b1;
   end

   AST_RFC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (since_ref < SW_W'(T_RFC)) |-> cmd_q == CMD_NOP); // R9
   AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      !cke_q |-> cmd_q == CMD_NOP); // R1
   AST_REF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ref_due |=> !(cmd_q == CMD_ACT || cmd_q == CMD_RD || cmd_q == CMD_WR)); // R10
   AST_READY_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> (cmd_q == CMD_RD || cmd_q == CMD_WR) && ba_q == $past(req_bank)); // R3

   assign cmd_bits  = cmd_q;
   assign ddr_cs_n  = cmd_bits[3];
   assign ddr_ras_n = cmd_bits[2];
   assign ddr_cas_n = cmd_bits[1];
   assign ddr_we_n  = cmd_bits[0];
   assign ddr_ba    = ba_q;
   assign ddr_addr  = a_q;
   assign ddr_cke   = cke_q;
   assign init_done = (state == ST_RUN);

endmodule

// File: tb/ddr_cmd_seq_tb.sv
`timescale 1ns/1ps
module ddr_cmd_seq_tb;
   localparam int BL       = 4;
   localparam int T_RCD    = 3;
   localparam int T_RP     = 3;
   localparam int T_RC     = 11;
   localparam int T_RFC    = 14;
   localparam int T_REFI   = 1562;
   localparam int INIT_CYC = 20;
   localparam int T_AP     = BL / 2 + T_RP;
   localparam int SLACK    = 32;

   localparam logic [3:0] K_LMR = 4'b0000, K_REF = 4'b0001, K_PRE = 4'b0010,
                          K_ACT = 4'b0011, K_WR  = 4'b0100, K_RD  = 4'b0101,
                          K_NOP = 4'b0111;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
   logic [1:0]  req_bank = '0;
   logic [12:0] req_row = '0;
   logic [10:0] req_col = '0;
   logic        req_ready, init_done, cke, cs_n, ras_n, cas_n, we_n;
   logic [1:0]  ba;
   logic [12:0] addr;

   ddr_cmd_seq #(
      .BURST_LEN (BL), .T_RCD (T_RCD), .T_RP (T_RP), .T_RC (T_RC),
      .T_RFC (T_RFC), .T_REFI (T_REFI), .INIT_CYC (INIT_CYC)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
      .req_ap (req_ap), .req_bank (req_bank), .req_row (req_row), .req_col (req_col),
      .req_ready (req_ready), .init_done (init_done), .ddr_cke (cke),
      .ddr_cs_n (cs_n), .ddr_ras_n (ras_n), .ddr_cas_n (cas_n), .ddr_we_n (we_n),
      .ddr_ba (ba), .ddr_addr (addr)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0, n_bad = 0, cyc = 0;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
      end
   endtask

   function automatic int mode_exp(input int bl);
      int code;
      code = (bl == 2) ? 1 : (bl == 4) ? 2 : 3;
      return (3 << 4) | code;
   endfunction

   // bank-state scoreboard
   bit          m_open [4];
   logic [12:0] m_row  [4];
   int          t_act  [4];
   int          t_pre  [4];
   int          t_ref = -1, n_cmd = 0, t_first = 0;
   int          acts = 0, pres = 0, refs = 0, accs = 0;
   bit          exp_live = 0, exp_w = 0, exp_ap = 0;
   logic [1:0]  exp_b = '0;
   logic [12:0] exp_row = '0;
   logic [10:0] exp_col = '0;

   initial for (int i = 0; i < 4; i++) begin t_act[i] = -1000; t_pre[i] = -1000; end

   always @(negedge clk) if (rst_n) begin
      logic [3:0] c;
      c = {cs_n, ras_n, cas_n, we_n};
      if (!cke) chk(c == K_NOP, "R1 nop while cke low", c, K_NOP);
      if (c != K_NOP) begin
         if (t_ref >= 0) chk(cyc - t_ref >= T_RFC, "R9 quiet after refresh", cyc - t_ref, T_RFC);
         if (n_cmd == 0) begin
            chk(c == K_PRE && addr[10], "R1 first command precharge-all", c, K_PRE);
            chk(cyc >= INIT_CYC, "R1 cke hold", cyc, INIT_CYC);
            t_first = cyc;
         end else if (n_cmd == 1) begin
            chk(c == K_LMR && ba == 2'b01 && addr == 0, "R1 extended mode load", {c, ba}, {K_LMR, 2'b01});
            chk(cyc - t_first >= T_RP, "R1 precharge to load", cyc - t_first, T_RP);
         end else if (n_cmd == 2) begin
            chk(c == K_LMR && ba == 2'b00, "R1 base mode load", {c, ba}, {K_LMR, 2'b00});
            chk(int'(addr) == mode_exp(BL), "R11 mode word", addr, mode_exp(BL));
         end
         n_cmd++;
         case (c)
            K_ACT: begin
               chk(!m_open[ba], "R7 activate on closed bank", m_open[ba], 0);
               chk(cyc - t_pre[ba] >= T_RP, "R5 precharge to activate", cyc - t_pre[ba], T_RP);
               chk(cyc - t_act[ba] >= T_RC, "R6 activate to activate", cyc - t_act[ba], T_RC);
               m_open[ba] = 1; m_row[ba] = addr; t_act[ba] = cyc; acts++;
            end
            K_RD, K_WR: begin
               chk(m_open[ba], "R7 access on open bank", m_open[ba], 1);
               chk(cyc - t_act[ba] >= T_RCD, "R4 activate to access", cyc - t_act[ba], T_RCD);
               chk(addr[12] == 1'b0, "R3 A12 zero", addr[12], 0);
               if (exp_live) begin
                  chk(ba == exp_b, "R3 bank", ba, exp_b);
                  chk({addr[11], addr[9:0]} == exp_col, "R3 column mapping", {addr[11], addr[9:0]}, exp_col);
                  chk(addr[10] == exp_ap, "R3 auto-precharge flag", addr[10], exp_ap);
                  chk(c == (exp_w ? K_WR : K_RD), "R2 command code", c, exp_w ? K_WR : K_RD);
                  chk(m_row[ba] == exp_row, "R7 open row matches request", m_row[ba], exp_row);
                  exp_live = 0;
               end
               if (addr[10]) begin m_open[ba] = 0; t_pre[ba] = cyc + BL / 2; end
               accs++;
            end
            K_PRE: begin
               for (int i = 0; i < 4; i++)
                  if (addr[10] || ba == i[1:0]) begin m_open[i] = 0; t_pre[i] = cyc; end
               pres++;
            end
            K_REF: begin
               for (int i = 0; i < 4; i++) begin
                  chk(!m_open[i], "R9 banks closed at refresh", m_open[i], 0);
                  chk(cyc - t_pre[i] >= T_RP && cyc - t_act[i] >= T_RC, "R9 bank recovered", cyc - t_pre[i], T_RP);
               end
               if (t_ref >= 0) chk(cyc - t_ref <= T_REFI + SLACK, "R10 refresh interval", cyc - t_ref, T_REFI + SLACK);
               t_ref = cyc; refs++;
            end
            K_LMR: chk(n_cmd <= 3, "R2 load mode only at init", n_cmd, 3);
            default: chk(0, "R2 illegal code", c, K_NOP);
         endcase
      end
   end

   task automatic do_req(input bit w, input logic [1:0] b, input logic [12:0] r,
                         input logic [10:0] col, input bit ap,
                         output int d_act, output int d_pre, output int d_ref);
      int a0, p0, f0, n0;
      @(negedge clk);
      a0 = acts; p0 = pres; f0 = refs; n0 = accs;
      exp_w = w; exp_b = b; exp_row = r; exp_col = col; exp_ap = ap; exp_live = 1;
      req_write = w; req_bank = b; req_row = r; req_col = col; req_ap = ap; req_valid = 1;
      #0.5;
      while (!req_ready) begin @(negedge clk); #0.5; end
      @(posedge clk);
      #0.5 req_valid = 0;
      while (accs == n0) @(negedge clk);
      d_act = acts - a0; d_pre = pres - p0; d_ref = refs - f0;
   endtask

   initial begin
      int da, dp, dr;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(cke == 0, "R1 reset cke", cke, 0);
      chk({cs_n, ras_n, cas_n, we_n} == K_NOP, "R1 reset NOP", {cs_n, ras_n, cas_n, we_n}, K_NOP);
      rst_n = 1;
      while (!init_done) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(n_cmd == 3, "R1 init command count", n_cmd, 3);

      // closed bank, all column bits set
      do_req(0, 2'd0, 13'd5, 11'h7FF, 0, da, dp, dr);
      chk(da == 1, "R7 activate for closed bank", da, 1);
      // row hit
      do_req(1, 2'd0, 13'd5, 11'h400, 0, da, dp, dr);
      if (dr == 0) chk(da == 0 && dp == 0, "R8 hit needs no extra commands", da + dp, 0);
      // row miss
      do_req(0, 2'd0, 13'd9, 11'h0AA, 0, da, dp, dr);
      if (dr == 0) chk(da == 1 && dp == 1, "R7 miss closes then opens", {da[3:0], dp[3:0]}, 8'h11);
      // auto-precharge, then same row again
      do_req(1, 2'd1, 13'h1FFF, 11'h155, 1, da, dp, dr);
      do_req(0, 2'd1, 13'h1FFF, 11'h2AA, 0, da, dp, dr);
      if (dr == 0) chk(da == 1 && dp == 0, "R5 reopen after auto-precharge", da, 1);

      // random back-to-back traffic
      for (int k = 0; k < 400; k++) begin
         logic [12:0] r;
         r = 13'(($urandom % 3) * 4097);
         do_req(1'($urandom), 2'($urandom), r, 11'($urandom), ($urandom % 4) == 0, da, dp, dr);
      end

      // idle stretch
      repeat (2 * T_REFI + 100) @(negedge clk);
      chk(refs >= cyc / T_REFI - 1, "R9 refreshes keep coming", refs, cyc / T_REFI - 1);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule